// File: doc/BRIEF.md
# Predicate Register File with Commit/Squash Decision

This block keeps a bank of one-bit predicate flags and, for every instruction that reaches the last pipeline stage, decides whether that instruction is allowed to commit or must be squashed. Each retiring instruction names one flag as its qualifying predicate. A set flag lets the instruction commit, and a clear flag cancels it. The comparison arithmetic and the rest of the pipeline live elsewhere.

A compare instruction writes two flags at once. The first named destination receives the compare result and the second receives its inverse. This lets both arms of a condition be issued back to back with no jump, and the arm whose flag is clear is discarded at retire.

Flag 0 always reads as one and cannot be written, so instructions that need no condition name flag 0. A compare write and a retire that read the same flag in one cycle are resolved by a bypass: the retire sees the value being written.

Top module: `predSquash`

## Requirements
- R1: After reset, every flag with index 1 to 63 reads as 0, so a retire qualified by any of them is cancelled.
- R2: Flag 0 always reads as 1. A retire qualified by flag 0 always commits, and a compare naming index 0 as a destination leaves it unchanged.
- R3: A valid compare writes `cmpResult` into flag `cmpDstA` and the inverse of `cmpResult` into flag `cmpDstB`. A retire in any later cycle sees these values.
- R4: When `retValid` is 0, both `retCommit` and `retCancel` are 0, whatever the other inputs are.
- R5: When `retValid` is 1, exactly one output is high. `retCommit` is high when the selected flag reads 1, and `retCancel` is high when it reads 0. The outputs are combinational in the same cycle.
- R6: When a valid compare names the retire's qualifying index as a destination in the same cycle, the retire sees the value being written, not the stored one. This does not apply to index 0.
- R7: When `cmpDstA` equals `cmpDstB`, that flag takes `cmpResult`. This holds both for the same-cycle bypass and for the stored value.
- R8: A flag keeps its value across cycles in which no compare names it. Writes to other flags do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmpValid | input | 1 | A compare result is being written this cycle |
| cmpDstA | input | 6 | Flag that receives the compare result |
| cmpDstB | input | 6 | Flag that receives the inverted compare result |
| cmpResult | input | 1 | Compare outcome |
| retValid | input | 1 | An instruction retires this cycle |
| retQp | input | 6 | Qualifying flag index of the retiring instruction |
| retCommit | output | 1 | The retiring instruction commits |
| retCancel | output | 1 | The retiring instruction is squashed |

## Verification
The compare write and the retire read can land on the same flag in the same cycle. The bench provokes this by sweeping every destination index while a retire reads that same index, and it includes cases where both destinations collide and cases where a destination is flag 0. The expected outcome comes from a bench-side model of all 64 flags. In that model, the incoming compare overrides the stored value, the first destination takes priority, and index 0 is fixed at one. The same model then checks in the following cycle that the stored value matches what was bypassed.

// File: rtl/predPkg.sv
package predPkg;
  // Strobes from the control decode to the flag datapath.
  typedef struct packed {
    logic wrA;     // write the first destination
    logic wrB;     // write the second destination
    logic valA;    // value for the first destination
    logic valB;    // value for the second destination
    logic hitA;    // retire index matches the first destination this cycle
    logic hitB;    // retire index matches the second destination this cycle
    logic qpZero;  // retire names the fixed-one flag
  } predStrobeT;
endpackage

// File: rtl/predCtrl.sv
module predCtrl
  import predPkg::*;
#(
  parameter int IdxW = 6
) (
  input  logic            cmpValid,
  input  logic [IdxW-1:0] cmpDstA,
  input  logic [IdxW-1:0] cmpDstB,
  input  logic            cmpResult,
  input  logic [IdxW-1:0] retQp,
  output predStrobeT      strobe
);
  logic dstAZero;
  logic dstBZero;
  logic sameDst;

  always_comb begin
    dstAZero = (cmpDstA == '0);
    dstBZero = (cmpDstB == '0);
    sameDst  = (cmpDstA == cmpDstB);

    strobe.wrA    = cmpValid && !dstAZero;
    // The first destination wins a collision, so the second write is dropped.
    strobe.wrB    = cmpValid && !dstBZero && !sameDst;
    strobe.valA   = cmpResult;
    strobe.valB   = !cmpResult;
    strobe.qpZero = (retQp == '0);
    strobe.hitA   = strobe.wrA && (cmpDstA == retQp);
    strobe.hitB   = strobe.wrB && (cmpDstB == retQp);
  end
endmodule

// File: rtl/predData.sv
module predData
  import predPkg::*;
#(
  parameter int NumPred = 64,
  localparam int IdxW = $clog2(NumPred)
) (
  input  logic            clk,
  input  logic            rstN,
  input  predStrobeT      strobe,
  input  logic [IdxW-1:0] cmpDstA,
  input  logic [IdxW-1:0] cmpDstB,
  input  logic [IdxW-1:0] retQp,
  output logic            predRead
);
  logic [NumPred-1:0] predQ;

  for (genvar gi = 0; gi < NumPred; gi++) begin : g_flag
    if (gi == 0) begin : g_fixed
      assign predQ[gi] = 1'b1;
    end else begin : g_reg
      logic selA;
      logic selB;
      assign selA = strobe.wrA && (cmpDstA == IdxW'(gi));
      assign selB = strobe.wrB && (cmpDstB == IdxW'(gi));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)     predQ[gi] <= 1'b0;
        else if (selA) predQ[gi] <= strobe.valA;
        else if (selB) predQ[gi] <= strobe.valB;
      end
    end
  end

  always_comb begin
    if (strobe.qpZero)    predRead = 1'b1;
    else if (strobe.hitA) predRead = strobe.valA;
    else if (strobe.hitB) predRead = strobe.valB;
    else                  predRead = predQ[retQp];
  end
endmodule

// File: rtl/predSquash.sv
module predSquash
  import predPkg::*;
#(
  parameter int NumPred = 64,
  localparam int IdxW = $clog2(NumPred)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmpValid,
  input  logic [IdxW-1:0] cmpDstA,
  input  logic [IdxW-1:0] cmpDstB,
  input  logic            cmpResult,
  input  logic            retValid,
  input  logic [IdxW-1:0] retQp,
  output logic            retCommit,
  output logic            retCancel
);
  predStrobeT strobe;
  logic       predRead;

  predCtrl #(.IdxW(IdxW)) u_ctrl (
    .cmpValid (cmpValid),
    .cmpDstA  (cmpDstA),
    .cmpDstB  (cmpDstB),
    .cmpResult(cmpResult),
    .retQp    (retQp),
    .strobe   (strobe)
  );

  predData #(.NumPred(NumPred)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmpDstA (cmpDstA),
    .cmpDstB (cmpDstB),
    .retQp   (retQp),
    .predRead(predRead)
  );

  assign retCommit = retValid && predRead;
  assign retCancel = retValid && !predRead;
endmodule

// File: rtl/predSquashChk.sv
module predSquashChk #(
  parameter int IdxW = 6
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmpValid,
  input logic [IdxW-1:0] cmpDstA,
  input logic [IdxW-1:0] cmpDstB,
  input logic            cmpResult,
  input logic            retValid,
  input logic [IdxW-1:0] retQp,
  input logic            retCommit,
  input logic            retCancel
);
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !retValid |-> (!retCommit && !retCancel));

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rstN)
    retValid |-> $onehot({retCommit, retCancel}));

  assert_flag_zero_commits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && retQp == '0) |-> retCommit);

  // R7: the first destination wins, even when both destinations name the same flag.
  assert_bypass_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && cmpValid && retQp != '0 && cmpDstA == retQp) |-> (retCommit == cmpResult));

  assert_bypass_second_R6: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && cmpValid && retQp != '0 && cmpDstB == retQp && cmpDstA != retQp)
      |-> (retCommit == !cmpResult));

  assert_stored_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && cmpDstA != '0) |=>
      (!(retValid && retQp == $past(cmpDstA) &&
         !(cmpValid && (cmpDstA == retQp || cmpDstB == retQp)))
       || (retCommit == $past(cmpResult))));
endmodule

bind predSquash predSquashChk #(.IdxW(IdxW)) u_predSquashChk (
  .clk      (clk),
  .rstN     (rstN),
  .cmpValid (cmpValid),
  .cmpDstA  (cmpDstA),
  .cmpDstB  (cmpDstB),
  .cmpResult(cmpResult),
  .retValid (retValid),
  .retQp    (retQp),
  .retCommit(retCommit),
  .retCancel(retCancel)
);

// File: tb/test_predSquash.sv
`timescale 1ns/1ps
module test_predSquash;
  localparam int NumPred = 64;
  localparam int IdxW = 6;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cmpValid = 1'b0;
  logic [IdxW-1:0] cmpDstA = '0;
  logic [IdxW-1:0] cmpDstB = '0;
  logic            cmpResult = 1'b0;
  logic            retValid = 1'b0;
  logic [IdxW-1:0] retQp = '0;
  logic            retCommit;
  logic            retCancel;

  int checks = 0;
  int fails = 0;
  logic model [NumPred];

  always #10 clk = ~clk;

  predSquash #(.NumPred(NumPred)) i_predSquash (
    .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .cmpDstA(cmpDstA),
    .cmpDstB(cmpDstB), .cmpResult(cmpResult), .retValid(retValid),
    .retQp(retQp), .retCommit(retCommit), .retCancel(retCancel)
  );

  // One cycle: drive after the rising edge, compare at the falling edge, then update the model.
  task automatic step(input logic cv, input int a, input int b, input logic r,
                      input logic rv, input int q, input string tag);
    logic p;
    logic [1:0] expOut;
    @(posedge clk);
    #1;
    cmpValid = cv; cmpDstA = IdxW'(a); cmpDstB = IdxW'(b); cmpResult = r;
    retValid = rv; retQp = IdxW'(q);
    @(negedge clk);
    if (q == 0)              p = 1'b1;
    else if (cv && a == q)   p = r;
    else if (cv && b == q)   p = ~r;
    else                     p = model[q];
    expOut = {rv & p, rv & ~p};
    checks++;
    if ({retCommit, retCancel} !== expOut) begin
      fails++;
      $display("FAIL %s: qp=%0d commit/cancel actual=%b expected=%b",
               tag, q, {retCommit, retCancel}, expOut);
    end
    if (cv) begin
      if (b != 0) model[b] = ~r;
      if (a != 0) model[a] = r;
    end
  endtask

  initial begin
    for (int i = 0; i < NumPred; i++) model[i] = (i == 0);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // Reset state of every flag.
    for (int q = 0; q < NumPred; q++)
      step(1'b0, 0, 0, 1'b0, 1'b1, q, (q == 0) ? "R2" : "R1");

    // No retire: both outputs low, even with a compare on the same flag.
    step(1'b1, 7, 8, 1'b1, 1'b0, 7, "R4");
    step(1'b0, 0, 0, 1'b0, 1'b0, 0, "R4");
    step(1'b0, 0, 0, 1'b0, 1'b1, 7, "R3");
    step(1'b0, 0, 0, 1'b0, 1'b1, 8, "R3");

    // Sweep all first destinations with a scrambled second destination.
    for (int a = 0; a < NumPred; a++) begin
      int b;
      logic r;
      b = (a * 37 + 11) % NumPred;
      r = logic'(a[0] ^ a[3]);
      step(1'b1, a, b, r, 1'b1, a, "R6");
      step(1'b0, 0, 0, 1'b0, 1'b1, a, "R3");
      step(1'b1, b, a, ~r, 1'b1, b, "R6");
      step(1'b0, 0, 0, 1'b0, 1'b1, a, "R3");
    end

    // Colliding destinations: the first one's value wins.
    for (int a = 0; a < NumPred; a += 5) begin
      step(1'b1, a, a, 1'b1, 1'b1, a, "R7");
      step(1'b0, 0, 0, 1'b0, 1'b1, a, "R7");
      step(1'b1, a, a, 1'b0, 1'b1, a, "R7");
      step(1'b0, 0, 0, 1'b0, 1'b1, a, "R7");
    end

    // Writes aimed at flag 0 are dropped.
    step(1'b1, 0, 0, 1'b0, 1'b1, 0, "R2");
    step(1'b0, 0, 0, 1'b0, 1'b1, 0, "R2");
    step(1'b1, 9, 0, 1'b1, 1'b1, 0, "R2");
    step(1'b0, 0, 0, 1'b0, 1'b1, 0, "R2");

    // Second-destination bypass, then the stored value.
    step(1'b1, 20, 21, 1'b0, 1'b1, 21, "R6");
    step(1'b0, 0, 0, 1'b0, 1'b1, 21, "R3");

    // Retention: read every flag back after many unrelated writes.
    for (int q = 0; q < NumPred; q++)
      step(1'b0, 0, 0, 1'b0, 1'b1, q, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule